// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns bytes from a single-entry holding buffer into asynchronous serial frames on one output line. A write strobe places a byte in the holding buffer. When the shifter is free and, if enabled, the far end signals clear-to-send, the byte moves into the shifter. It then goes out as a low start bit, five to eight data bits with the least significant bit first, an optional parity bit, and a stop period of one, one and a half or two bit times.

Frame format comes from a 7-bit format word. Bit timing comes from a 16x oversampling tick, produced by dividing the clock by a 16-bit divisor. Two flags report progress. One shows that the holding buffer is empty. The other shows that the whole transmit path is idle. A break control holds the line low for as long as it is set.

Top module: `sertx_top`

## Requirements
- R1: Format bits [1:0] select the character length: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R2: A frame starts with one low start bit, followed by the data bits with the least significant bit first. Every start, data and parity bit lasts 16 ticks.
- R3: Format bits [5:3] choose the parity bit: xx0 sends none, 001 sends odd parity, 011 sends even parity, 101 sends a constant 1 and 111 sends a constant 0.
- R4: With format bit 2 at 0 the stop period is 16 ticks at line level 1. With bit 2 at 1 it is 24 ticks for 5-bit characters and 32 ticks for 6, 7 or 8-bit characters.
- R5: While format bit 6 is 1, `txd` is 0 regardless of state. Clearing the bit returns the line to the value the transmitter is driving.
- R6: One tick equals `divisor` clock cycles, and a divisor of 0 acts as 1. A frame lasts its tick count times the effective divisor, measured from the start bit to the return of `tx_idle`.
- R7: `hold_empty` goes to 0 on the cycle after a write. It returns to 1 on the cycle after the byte moves into the shifter, which is the cycle the start bit appears.
- R8: `tx_idle` is 1 only when the holding buffer is empty and no character is in progress. The line is 1 when idle without break. A byte written during a character is sent next, and `tx_idle` stays 0 in between.
- R9: While `rst_n` is low, `txd`, `hold_empty` and `tx_idle` are all 1 (break clear), including when reset arrives mid-frame.
- R10: With `flow_en` at 1 and `cts_n` at 1, no new character starts. A character already under way always completes at full length.
- R11: Format and parity are captured when a character starts. Changing format bits [5:0] mid-character does not change that character.
- R12: A write while the holding buffer is still full replaces the waiting byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe into the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| line_fmt | input | 7 | Format word: [1:0] length, [2] stop, [5:3] parity, [6] break |
| divisor | input | 16 | Clock cycles per 16x tick (0 acts as 1) |
| cts_n | input | 1 | Clear-to-send, active low |
| flow_en | input | 1 | Enables clear-to-send gating of new characters |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding buffer empty |
| tx_idle | output | 1 | Holding buffer empty and shifter finished |

## Verification
The assertions assume that `divisor` stays constant while a character is being sent, so that each tick spacing follows the value present when the counter reloads. They also assume that `line_fmt`, `cts_n` and `flow_en` change only between clock edges. The stimulus changes the divisor only while the transmitter is idle. It drives every input on the falling clock edge and changes format or clear-to-send mid-frame only in the tests that check those cases.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int CHAR_MAX = 8;
  localparam int CHAR_MIN = 5;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PARITY,
    TX_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_ODD,
    PAR_EVEN,
    PAR_MARK,
    PAR_SPACE
  } par_kind_e;

  typedef enum logic [1:0] {
    STOP_ONE,
    STOP_ONE_HALF,
    STOP_TWO
  } stop_len_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    par_kind_e  par_kind;
    stop_len_e  stop_sel;
  } frame_fmt_t;

endpackage

// File: rtl/sertx_fmt.sv
module sertx_fmt
  import sertx_pkg::*;
(
  input  logic [5:0] fmt_word,
  output frame_fmt_t fmt
);

  always_comb begin
    fmt.nbits  = 4'(CHAR_MIN) + {2'b00, fmt_word[1:0]};
    fmt.par_en = fmt_word[3];
    case (fmt_word[5:4])
      2'b00:   fmt.par_kind = PAR_ODD;
      2'b01:   fmt.par_kind = PAR_EVEN;
      2'b10:   fmt.par_kind = PAR_MARK;
      default: fmt.par_kind = PAR_SPACE;
    endcase
    if (!fmt_word[2]) begin
      fmt.stop_sel = STOP_ONE;
    end else if (fmt_word[1:0] == 2'b00) begin
      fmt.stop_sel = STOP_ONE_HALF;
    end else begin
      fmt.stop_sel = STOP_TWO;
    end
  end

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] reload;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    reload  = div_eff - DIV_W'(1);
    tick    = run && (cnt_q == '0);
    cnt_en  = 1'b1;
    if (!run) begin
      cnt_d  = reload;
      cnt_en = (cnt_q != reload);
    end else if (cnt_q == '0) begin
      cnt_d = reload;
    end else begin
      cnt_d = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q;
  logic              full_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    full_d = wr_en | (full_q & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_en) begin
      data_q <= wr_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  logic [CHAR_MAX-1:0] din,
  input  frame_fmt_t          fmt_in,
  output logic                line_o,
  output logic                busy
);

  localparam int TW = $clog2(2 * OVS);

  tx_state_e           state_q, state_d;
  logic [TW-1:0]       ticks_q, ticks_d;
  logic [3:0]          bits_q, bits_d;
  logic [CHAR_MAX-1:0] sh_q, sh_d;
  logic [3:0]          nbits_q, nbits_d;
  logic                pen_q, pen_d;
  stop_len_e           stop_q, stop_d;
  logic                par_q, par_d;
  logic                par_calc;
  logic [TW-1:0]       stop_last;
  logic [TW-1:0]       seg_last;
  logic                upd_en;

  // parity over the live data bits of the incoming byte
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (i < int'(fmt_in.nbits)) acc = acc ^ din[i];
    end
    case (fmt_in.par_kind)
      PAR_ODD:  par_calc = ~acc;
      PAR_EVEN: par_calc = acc;
      PAR_MARK: par_calc = 1'b1;
      default:  par_calc = 1'b0;
    endcase
  end

  always_comb begin
    case (stop_q)
      STOP_ONE:      stop_last = TW'(OVS - 1);
      STOP_ONE_HALF: stop_last = TW'(OVS + OVS / 2 - 1);
      default:       stop_last = TW'(2 * OVS - 1);
    endcase
    seg_last = (state_q == TX_STOP) ? stop_last : TW'(OVS - 1);
  end

  always_comb begin
    state_d = state_q;
    ticks_d = ticks_q;
    bits_d  = bits_q;
    sh_d    = sh_q;
    nbits_d = nbits_q;
    pen_d   = pen_q;
    stop_d  = stop_q;
    par_d   = par_q;
    upd_en  = 1'b0;
    if (state_q == TX_IDLE) begin
      if (start) begin
        upd_en  = 1'b1;
        state_d = TX_START;
        ticks_d = '0;
        bits_d  = '0;
        sh_d    = din;
        nbits_d = fmt_in.nbits;
        pen_d   = fmt_in.par_en;
        stop_d  = fmt_in.stop_sel;
        par_d   = par_calc;
      end
    end else if (tick) begin
      upd_en = 1'b1;
      if (ticks_q == seg_last) begin
        ticks_d = '0;
        case (state_q)
          TX_START: state_d = TX_DATA;
          TX_DATA: begin
            if (bits_q == nbits_q - 4'd1) begin
              state_d = pen_q ? TX_PARITY : TX_STOP;
            end else begin
              bits_d = bits_q + 4'd1;
              sh_d   = sh_q >> 1;
            end
          end
          TX_PARITY: state_d = TX_STOP;
          default:   state_d = TX_IDLE;
        endcase
      end else begin
        ticks_d = ticks_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      ticks_q <= '0;
      bits_q  <= '0;
      sh_q    <= '0;
      nbits_q <= 4'(CHAR_MIN);
      pen_q   <= 1'b0;
      stop_q  <= STOP_ONE;
      par_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      ticks_q <= ticks_d;
      bits_q  <= bits_d;
      sh_q    <= sh_d;
      nbits_q <= nbits_d;
      pen_q   <= pen_d;
      stop_q  <= stop_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    case (state_q)
      TX_START:  line_o = 1'b0;
      TX_DATA:   line_o = sh_q[0];
      TX_PARITY: line_o = par_q;
      default:   line_o = 1'b1;
    endcase
  end

  assign busy = (state_q != TX_IDLE);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVS        = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [6:0]       line_fmt,
  input  logic [DIV_W-1:0] divisor,
  input  logic             cts_n,
  input  logic             flow_en,
  output logic             txd,
  output logic             hold_empty,
  output logic             tx_idle
);

  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_int_n;
  logic                  tx_busy;
  logic                  baud_tick;
  logic                  hold_full;
  logic [CHAR_MAX-1:0]   hold_data;
  logic                  start_go;
  logic                  send_ok;
  logic                  line_bit;
  frame_fmt_t            fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[RST_STAGES-1];

  always_comb begin
    send_ok  = !flow_en || !cts_n;
    start_go = hold_full && !tx_busy && send_ok;
  end

  sertx_fmt u_fmt (
    .fmt_word (line_fmt[5:0]),
    .fmt      (fmt)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (tx_busy),
    .divisor (divisor),
    .tick    (baud_tick)
  );

  sertx_hold #(.DATA_W(CHAR_MAX)) u_hold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (start_go),
    .full    (hold_full),
    .data    (hold_data)
  );

  sertx_shift #(.OVS(OVS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (baud_tick),
    .start  (start_go),
    .din    (hold_data),
    .fmt_in (fmt),
    .line_o (line_bit),
    .busy   (tx_busy)
  );

  assign txd        = line_bit & ~line_fmt[6];
  assign hold_empty = ~hold_full;
  assign tx_idle    = ~hold_full & ~tx_busy;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             brk,
  input logic [DIV_W-1:0] divisor,
  input logic             cts_n,
  input logic             flow_en,
  input logic             txd,
  input logic             hold_empty,
  input logic             tx_idle,
  input logic             busy,
  input logic             tick
);

  p_reset_flags_r9: assert property (@(posedge clk)
    !rst_n |-> (hold_empty && tx_idle));

  p_idle_needs_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> hold_empty);

  p_idle_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !brk) |-> txd);

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !brk) |-> !txd);

  p_flow_blocks_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && cts_n && !busy) |=> !busy);

  p_fill_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_empty) |-> $past(wr_en));

  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (divisor > DIV_W'(1))) |=> !tick);

  p_tick_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);

endmodule

bind sertx_top sertx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .brk        (line_fmt[6]),
  .divisor    (divisor),
  .cts_n      (cts_n),
  .flow_en    (flow_en),
  .txd        (txd),
  .hold_empty (hold_empty),
  .tx_idle    (tx_idle),
  .busy       (tx_busy),
  .tick       (baud_tick)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [6:0]  line_fmt = 7'h03;
  logic [15:0] divisor = 16'd1;
  logic        cts_n = 1'b0;
  logic        flow_en = 1'b0;
  logic        txd;
  logic        hold_empty;
  logic        tx_idle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sertx_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .line_fmt   (line_fmt),
    .divisor    (divisor),
    .cts_n      (cts_n),
    .flow_en    (flow_en),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_idle    (tx_idle)
  );

  // {format, data, divisor, expected ticks per frame}
  localparam logic [41:0] VEC [0:9] = '{
    {8'h03, 8'hA5, 16'd1, 10'd160},  // 8N1
    {8'h00, 8'h15, 16'd2, 10'd112},  // 5N1
    {8'h04, 8'h0A, 16'd1, 10'd120},  // 5N1.5
    {8'h07, 8'h3C, 16'd1, 10'd176},  // 8N2
    {8'h0B, 8'h01, 16'd1, 10'd176},  // 8 odd 1
    {8'h1A, 8'h7F, 16'd1, 10'd160},  // 7 even 1
    {8'h2B, 8'h00, 16'd1, 10'd176},  // 8 mark 1
    {8'h3D, 8'h2A, 16'd1, 10'd160},  // 6 space 2
    {8'h05, 8'h3F, 16'd3, 10'd144},  // 6N2 slow
    {8'h03, 8'h5A, 16'd0, 10'd160}   // divisor 0 acts as 1
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(hold_empty == 1'b0, "R7", "hold_empty after write", int'(hold_empty), 0);
  endtask

  // expected line levels from start bit through parity
  task automatic build(input logic [6:0] lc, input logic [7:0] d,
                       output logic [11:0] v, output int n, output int p);
    logic acc;
    v   = '0;
    n   = 5 + int'(lc[1:0]);
    p   = int'(lc[3]);
    acc = 1'b0;
    for (int i = 0; i < n; i++) begin
      v[i+1] = d[i];
      acc    = acc ^ d[i];
    end
    if (p == 1) begin
      if (lc[5]) v[n+1] = ~lc[4];
      else       v[n+1] = lc[4] ? acc : ~acc;
    end
  endtask

  // mid_act: 0 none, 1 raise cts_n at cycle 40, 2 flip stop bit at cycle 40
  task automatic run_frame(input logic [6:0] lc, input logic [7:0] d,
                           input int dv, input int exp_ticks, input int mid_act);
    logic [11:0] v;
    int n, p, nb, dd, w, idx;
    bit done;
    build(lc, d, v, n, p);
    nb = 1 + n + p;
    dd = (dv == 0) ? 1 : dv;
    w  = 0;
    while (txd !== 1'b0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 5000, "R2", "start bit seen", w, 0);
    chk(hold_empty == 1'b1, "R7", "hold_empty at start bit", int'(hold_empty), 1);
    done = 1'b0;
    for (int c = 0; c < 20000 && !done; c++) begin
      if (tx_idle === 1'b1) begin
        chk(c == exp_ticks * dd, "R1 R4 R6", "frame length", c, exp_ticks * dd);
        done = 1'b1;
      end else begin
        if ((c % (16 * dd)) == 8 * dd) begin
          idx = c / (16 * dd);
          if (idx < nb) begin
            if (idx == n + 1)
              chk(txd == v[idx], "R3", "parity bit", int'(txd), int'(v[idx]));
            else
              chk(txd == v[idx], "R2", "start/data bit", int'(txd), int'(v[idx]));
          end else if (idx == nb) begin
            chk(txd == 1'b1, "R4", "stop level", int'(txd), 1);
          end
        end
        if (c == 40 && mid_act == 1) cts_n = 1'b1;
        if (c == 40 && mid_act == 2) line_fmt = line_fmt ^ 7'h04;
        @(negedge clk);
      end
    end
    if (!done) chk(1'b0, "R6", "frame ended", 0, 1);
  endtask

  initial begin
    int c;
    bit stay;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && hold_empty && tx_idle, "R9", "reset outputs",
        {txd, hold_empty, tx_idle}, 3'b111);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && hold_empty && tx_idle, "R9", "after release",
        {txd, hold_empty, tx_idle}, 3'b111);

    // table of formats, data and divisors
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      line_fmt = VEC[k][40:34];
      divisor  = VEC[k][25:10];
      send(VEC[k][33:26]);
      run_frame(VEC[k][40:34], VEC[k][33:26], int'(VEC[k][25:10]),
                int'(VEC[k][9:0]), 0);
    end

    // R10 gating, R12 replace
    @(negedge clk);
    line_fmt = 7'h03;
    divisor  = 16'd1;
    flow_en  = 1'b1;
    cts_n    = 1'b1;
    send(8'h55);
    send(8'hC3);
    stay = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_idle !== 1'b0) stay = 1'b0;
    end
    chk(stay, "R10", "no start while cts_n high", int'(stay), 1);
    cts_n = 1'b0;
    // data bits confirm the replacing byte (R12); cts_n raised mid-frame (R10)
    run_frame(7'h03, 8'hC3, 1, 160, 1);
    cts_n   = 1'b0;
    flow_en = 1'b0;

    // R11 format captured at start
    @(negedge clk);
    line_fmt = 7'h03;
    send(8'h96);
    run_frame(7'h03, 8'h96, 1, 160, 2);
    line_fmt = 7'h03;

    // R8 back-to-back characters
    send(8'h11);
    c = 0;
    repeat (3) begin
      @(negedge clk);
      c++;
    end
    chk(hold_empty == 1'b1 && tx_idle == 1'b0, "R8", "busy with empty buffer",
        {hold_empty, tx_idle}, 2'b10);
    wr_en   = 1'b1;
    wr_data = 8'h22;
    @(negedge clk);
    c++;
    wr_en = 1'b0;
    chk(hold_empty == 1'b0 && tx_idle == 1'b0, "R8", "second byte waiting",
        {hold_empty, tx_idle}, 2'b00);
    while (tx_idle !== 1'b1 && c < 2000) begin
      @(negedge clk);
      c++;
    end
    chk(c == 322, "R8", "idle only after both frames", c, 322);

    // R5 break
    @(negedge clk);
    line_fmt = 7'h43;
    stay = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (txd !== 1'b0) stay = 1'b0;
    end
    chk(stay, "R5", "break holds line low", int'(stay), 1);
    line_fmt = 7'h03;
    @(negedge clk);
    chk(txd == 1'b1, "R5", "line after break", int'(txd), 1);

    // R9 reset mid-frame
    send(8'h00);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(txd == 1'b1 && hold_empty && tx_idle, "R9", "mid-frame reset",
        {txd, hold_empty, tx_idle}, 3'b111);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule